// File: doc/BRIEF.md
# Dual-Mode Tuning Word Loader

This block is the host-side programming front end of a direct digital synthesizer. A host assembles a 40-bit setting word that holds a 32-bit frequency tuning word, a 5-bit phase offset, a power-down bit and a 2-bit control field. The host sends the word either as five bytes on an 8-bit bus or as a 40-bit serial stream on the bus's top bit. A load strobe clocks each byte or bit. A separate commit strobe copies the assembled word into a working register that drives the oscillator core. At the same moment a single-cycle pulse tells the core that new settings apply.

Both strobes come from an asynchronous host. Each passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. The loader starts in byte mode. A special control value switches it into serial mode, and only reset returns it to byte mode. Control values that are reserved for test are not applied. Instead they set a sticky error flag. Master reset clears the working register but keeps the assembly register, so the host can commit a word it loaded earlier.

Top module: `dds_word_loader`

## Requirements
- R1: After reset, freq_o, phase_o, pwrdn_o, serial_o, rsv_err_o and upd_pulse_o are all 0.
- R2: In byte mode each load strobe stores data_i into the slot chosen by a pointer and then advances the pointer. Slot 0 bits 7..3 are phase bits 4..0, bit 2 is power-down, and bits 1..0 are the control field. Slots 1, 2, 3 and 4 carry frequency bits 31..24, 23..16, 15..8 and 7..0.
- R3: Once five bytes have been stored, later load strobes change nothing until a commit strobe or a reset rewinds the pointer.
- R4: In serial mode each load strobe shifts in data_i[7] and ignores data_i[6:0]. Forty bits arrive in this order: frequency bit 0 up to frequency bit 31, then control bit 0, control bit 1, power-down, and phase bit 0 up to phase bit 4.
- R5: Outputs change only on a commit strobe. A commit copies the assembled frequency, phase and power-down fields to the outputs and rewinds the byte pointer to slot 0.
- R6: A byte-mode commit whose slot 0 low three bits are 011 switches the block to serial mode (serial_o=1). The block stays in serial mode until reset.
- R7: Some control fields are reserved: 01 and 10 in byte mode, and any nonzero value in serial mode. Committing a reserved field sets rsv_err_o, which stays set until reset. The outputs keep their values and no update pulse is issued.
- R8: Reset leaves the assembly register unchanged. A commit after reset with no new loads applies the word loaded before the reset.
- R9: Each applied commit produces exactly one upd_pulse_o that lasts one clock cycle.
- R10: A commit after fewer than five byte loads applies the bytes written so far, with the other slots keeping their earlier contents. The next load then goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| load_stb_i | input | 1 | Asynchronous load strobe, acts on its rising edge |
| commit_stb_i | input | 1 | Asynchronous commit strobe, acts on its rising edge |
| data_i | input | 8 | Byte bus; bit 7 is also the serial input |
| freq_o | output | 32 | Applied frequency tuning word |
| phase_o | output | 5 | Applied phase offset |
| pwrdn_o | output | 1 | Applied power-down bit |
| serial_o | output | 1 | 1 while the loader is in serial mode |
| rsv_err_o | output | 1 | Sticky flag: a reserved control field was committed |
| upd_pulse_o | output | 1 | One-cycle pulse when new settings are applied |

## Verification
Six byte-mode words are loaded and committed in turn. They set different mixes of phase bits, the power-down bit, and frequency bits at both ends, so a byte placed in the wrong slot or a bit reversal inside a byte gives a wrong output. Serial words use asymmetric frequency and phase values while the unused bus bits are held at 1, 0, 1, 0…, which exposes a reversed shift direction or a tap on the wrong bus bit. Directed sequences cover a sixth byte after a full load, commits after one and two bytes, a commit after reset with no new loads, the entry into serial mode, and reserved codes in both modes. Together they separate pointer saturation, pointer rewind, and the rule that reset keeps the assembly register.

// File: rtl/dwl_pkg.sv
// Package: shared widths and the layout of the 40-bit setting word.
// The packed layout equals the serial arrival order (first bit lands at bit 0),
// and its top byte equals parallel slot 0, so both modes write one register.
package dwl_pkg;
    localparam int FREQ_W  = 32;
    localparam int PHASE_W = 5;
    localparam int CTRL_W  = 2;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = FREQ_W + CTRL_W + 1 + PHASE_W;
    localparam int NUM_BYTES = WORD_W / BYTE_W;
    localparam int PTR_W   = $clog2(NUM_BYTES + 1);

    // Control field values with a defined meaning
    localparam logic [CTRL_W-1:0] CTRL_NORMAL   = 2'b00;
    localparam logic [CTRL_W-1:0] CTRL_SER_ENTRY = 2'b11;

    typedef enum logic {MODE_BYTE = 1'b0, MODE_SERIAL = 1'b1} load_mode_e;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;   // bits 39..35
        logic               pwrdn;   // bit 34
        logic [CTRL_W-1:0]  ctrl;    // bits 33..32
        logic [FREQ_W-1:0]  freq;    // bits 31..0
    } setting_t;
endpackage

// File: rtl/dwl_strobe_sync.sv
// Module: dwl_strobe_sync
// Brings an asynchronous strobe into the clk domain through STAGES flops and
// emits a one-cycle pulse on each rising edge. Assumes the strobe stays high
// and low for at least two clk cycles each.
module dwl_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    // Shift the strobe through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R9
endmodule

// File: rtl/dwl_assembler.sv
// Module: dwl_assembler
// Builds the 40-bit setting word. In byte mode a pointer selects which lane a
// load writes and saturates after the last lane. In serial mode each load
// shifts the bus top bit in at the word's top, so the first bit ends at bit 0.
// The assembly register has no reset, since master reset must keep it.
// A load coinciding with a commit is dropped.
module dwl_assembler
    import dwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_evt_i,
    input  logic              commit_evt_i,
    input  load_mode_e        mode_i,
    input  logic [BYTE_W-1:0] data_i,
    output setting_t          word_o
);
    logic [PTR_W-1:0]     ptr_q;
    logic [WORD_W-1:0]    asm_q;
    logic [WORD_W-1:0]    asm_d;
    logic [NUM_BYTES-1:0] lane_we;
    logic                 take_load;
    logic                 ptr_full;

    assign take_load = load_evt_i & ~commit_evt_i;
    assign ptr_full  = (ptr_q == PTR_W'(NUM_BYTES));

    // Lane b is written when the pointer names it; slot 0 is the top lane
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign lane_we[b] = (ptr_q == PTR_W'(NUM_BYTES - 1 - b));
    end

    // Next assembly value: shift in serial mode, lane write in byte mode
    always_comb begin
        asm_d = asm_q;
        if (take_load) begin
            if (mode_i == MODE_SERIAL) begin
                asm_d = {data_i[BYTE_W-1], asm_q[WORD_W-1:1]};
            end else begin
                for (int b = 0; b < NUM_BYTES; b++) begin
                    if (lane_we[b]) asm_d[b*BYTE_W +: BYTE_W] = data_i;
                end
            end
        end
    end

    // Assembly register, deliberately outside the reset domain
    always_ff @(posedge clk) begin
        asm_q <= asm_d;
    end

    // Byte pointer: rewinds on reset or commit, advances on byte loads until full
    always_ff @(posedge clk) begin
        if (!rst_n)                                              ptr_q <= '0;
        else if (commit_evt_i)                                   ptr_q <= '0;
        else if (load_evt_i && mode_i == MODE_BYTE && !ptr_full) ptr_q <= ptr_q + 1'b1;
    end

    assign word_o = setting_t'(asm_q);

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(NUM_BYTES));  // R2
    AST_PTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_full && !commit_evt_i) |=> ptr_full);  // R3
    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        commit_evt_i |=> (ptr_q == '0));  // R5
    AST_SERIAL_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SERIAL && !commit_evt_i) |=> $stable(ptr_q));  // R4
endmodule

// File: rtl/dwl_commit.sv
// Module: dwl_commit
// Owns the working register, the load mode and the sticky error flag. On a
// commit event it either applies the assembled fields (with a one-cycle
// pulse) or, for a reserved control field, only raises the error flag.
// Assumes commit events are single-cycle pulses.
module dwl_commit
    import dwl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_evt_i,
    input  setting_t           word_i,
    output logic [FREQ_W-1:0]  freq_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               pwrdn_o,
    output load_mode_e         mode_o,
    output logic               err_o,
    output logic               pulse_o
);
    logic       reserved;
    logic       enter_serial;
    load_mode_e mode_q;

    // Classify the control field under the current mode
    always_comb begin
        if (mode_q == MODE_SERIAL) begin
            reserved     = (word_i.ctrl != CTRL_NORMAL);
            enter_serial = 1'b0;
        end else begin
            reserved     = (word_i.ctrl != CTRL_NORMAL) && (word_i.ctrl != CTRL_SER_ENTRY);
            enter_serial = (word_i.ctrl == CTRL_SER_ENTRY) && !word_i.pwrdn;
        end
    end

    // Apply or reject a commit; reset clears settings, mode and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_o  <= '0;
            phase_o <= '0;
            pwrdn_o <= 1'b0;
            mode_q  <= MODE_BYTE;
            err_o   <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (commit_evt_i) begin
                if (reserved) begin
                    err_o <= 1'b1;
                end else begin
                    freq_o  <= word_i.freq;
                    phase_o <= word_i.phase;
                    pwrdn_o <= word_i.pwrdn;
                    pulse_o <= 1'b1;
                    if (enter_serial) mode_q <= MODE_SERIAL;
                end
            end
        end
    end

    assign mode_o = mode_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);  // R9
    AST_PULSE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_evt_i |=> !pulse_o);  // R9
    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_evt_i |=> ($stable(freq_o) && $stable(phase_o) && $stable(pwrdn_o)));  // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);  // R7
    AST_SERIAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SERIAL) |=> (mode_q == MODE_SERIAL));  // R6
endmodule

// File: rtl/dds_word_loader.sv
// Module: dds_word_loader (top)
// Host programming front end of a direct digital synthesizer: synchronizes the
// load and commit strobes, assembles the setting word in byte or serial mode,
// and commits it to the working register that feeds the oscillator core.
module dds_word_loader
    import dwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_stb_i,
    input  logic               commit_stb_i,
    input  logic [BYTE_W-1:0]  data_i,
    output logic [FREQ_W-1:0]  freq_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               pwrdn_o,
    output logic               serial_o,
    output logic               rsv_err_o,
    output logic               upd_pulse_o
);
    logic       load_evt;
    logic       commit_evt;
    load_mode_e mode;
    setting_t   asm_word;

    dwl_strobe_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (load_stb_i),
        .rise_o  (load_evt)
    );

    dwl_strobe_sync #(.STAGES(SYNC_STAGES)) u_commit_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (commit_stb_i),
        .rise_o  (commit_evt)
    );

    dwl_assembler u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_evt_i   (load_evt),
        .commit_evt_i (commit_evt),
        .mode_i       (mode),
        .data_i       (data_i),
        .word_o       (asm_word)
    );

    dwl_commit u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_evt_i (commit_evt),
        .word_i       (asm_word),
        .freq_o       (freq_o),
        .phase_o      (phase_o),
        .pwrdn_o      (pwrdn_o),
        .mode_o       (mode),
        .err_o        (rsv_err_o),
        .pulse_o      (upd_pulse_o)
    );

    assign serial_o = (mode == MODE_SERIAL);
endmodule

// File: tb/dds_word_loader_bench.sv
module dds_word_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic        commit_stb = 1'b0;
    logic [7:0]  data = 8'h00;
    logic [31:0] freq;
    logic [4:0]  phase;
    logic        pwrdn, serial, rsv_err, upd_pulse;

    int checks = 0;
    int failures = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dds_word_loader u_dds_word_loader (
        .clk(clk), .rst_n(rst_n), .load_stb_i(load_stb), .commit_stb_i(commit_stb),
        .data_i(data), .freq_o(freq), .phase_o(phase), .pwrdn_o(pwrdn),
        .serial_o(serial), .rsv_err_o(rsv_err), .upd_pulse_o(upd_pulse)
    );

    // Words in slot order: {slot0, freq}; control field 00
    localparam logic [39:0] VEC [6] = '{
        40'h00_0000_0001, 40'hF8_FFFF_FFFF, 40'h04_8000_0000,
        40'h50_1234_5678, 40'hA4_DEAD_BEEF, 40'h08_0000_0000
    };

    always @(negedge clk) if (upd_pulse) pulse_cnt <= pulse_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_stb(input bit is_commit);
        @(negedge clk);
        if (is_commit) commit_stb = 1'b1; else load_stb = 1'b1;
        repeat (3) @(negedge clk);
        if (is_commit) commit_stb = 1'b0; else load_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_byte(input logic [7:0] b);
        data = b;
        pulse_stb(1'b0);
    endtask

    task automatic load_par(input logic [39:0] w);
        for (int k = 0; k < 5; k++) load_byte(w[8*(4-k) +: 8]);
    endtask

    // Serial word in arrival layout: bit i is sent i-th; low bus bits toggled as noise
    task automatic load_ser(input logic [39:0] w);
        for (int i = 0; i < 40; i++) load_byte({w[i], (i % 2 == 0) ? 7'h55 : 7'h2A});
    endtask

    task automatic commit();
        pulse_cnt = 0;
        pulse_stb(1'b1);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_word(input string req, input logic [39:0] w);
        check(req, {32'h0, freq}, {32'h0, w[31:0]});
        check(req, {59'h0, phase}, {59'h0, w[39:35]});
        check(req, {63'h0, pwrdn}, {63'h0, w[34]});
    endtask

    initial begin
        logic [39:0] prev;
        do_reset();
        // R1: reset state
        check("R1", {24'h0, freq, phase, pwrdn, serial, rsv_err},  64'h0);
        check("R1", {63'h0, upd_pulse}, 64'h0);

        // R2 / R5 / R9: table of byte-mode words
        prev = 40'h0;
        for (int v = 0; v < 6; v++) begin
            load_par(VEC[v]);
            expect_word("R5 hold before commit", prev);
            commit();
            expect_word("R2", VEC[v]);
            check("R9 one pulse", 64'(pulse_cnt), 64'd1);
            prev = VEC[v];
        end

        // R3: sixth byte ignored
        load_par(40'h18_0102_0304);
        load_byte(8'hFF);
        commit();
        expect_word("R3", 40'h18_0102_0304);

        // R10: partial loads
        load_par(40'h10_1111_1111); commit();
        load_byte(8'h20); load_byte(8'h22); commit();
        expect_word("R10", 40'h20_2211_1111);
        load_byte(8'h00); commit();
        expect_word("R10 rewind", 40'h00_2211_1111);

        // R8: reset keeps assembly register
        load_par(40'h30_CAFE_0042); commit();
        do_reset();
        check("R1 after reset", {32'h0, freq}, 64'h0);
        commit();
        expect_word("R8", 40'h30_CAFE_0042);
        check("R8 pulse", 64'(pulse_cnt), 64'd1);

        // R6: enter serial mode with slot0 low bits 011
        load_par(40'h03_0000_0100); commit();
        check("R6 serial", {63'h0, serial}, 64'd1);
        check("R6 freq", {32'h0, freq}, 64'h100);
        check("R6 err", {63'h0, rsv_err}, 64'h0);

        // R4: serial loads
        load_ser({5'b10011, 1'b0, 2'b00, 32'h8421_0F0F}); commit();
        expect_word("R4", {5'b10011, 1'b0, 2'b00, 32'h8421_0F0F});
        load_ser({5'b00001, 1'b1, 2'b00, 32'h0000_0003}); commit();
        expect_word("R4 pd", {5'b00001, 1'b1, 2'b00, 32'h0000_0003});

        // R7: serial reserved control field
        load_ser({5'b11111, 1'b0, 2'b01, 32'hFFFF_0000}); commit();
        check("R7 serial err", {63'h0, rsv_err}, 64'd1);
        check("R7 serial no pulse", 64'(pulse_cnt), 64'd0);
        expect_word("R7 serial hold", {5'b00001, 1'b1, 2'b00, 32'h0000_0003});
        check("R6 stays serial", {63'h0, serial}, 64'd1);

        // R7: byte-mode reserved codes 01 and 10
        do_reset();
        check("R1 mode", {62'h0, serial, rsv_err}, 64'h0);
        load_par(40'h01_5555_5555); commit();
        check("R7 code01 err", {63'h0, rsv_err}, 64'd1);
        check("R7 code01 hold", {32'h0, freq}, 64'h0);
        check("R7 code01 no pulse", 64'(pulse_cnt), 64'd0);
        do_reset();
        load_par(40'h02_6666_6666); commit();
        check("R7 code10 err", {63'h0, rsv_err}, 64'd1);
        check("R7 code10 hold", {32'h0, freq}, 64'h0);
        check("R6 not serial", {63'h0, serial}, 64'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule